// File: doc/BRIEF.md
# DRAM Write Command Sequencer

This block sits on the controller side of a DRAM interface and turns single-bank write requests into the command stream one bank group needs. A request names a bank, a row, a starting column, how many column writes follow the first one, and whether the row should be closed once the writes are done. The block holds, for each bank, whether a row is open and which row it is. It sorts every request into one of three cases. A page hit needs only column writes. A page miss needs a precharge, then an activate, then the writes. A page empty needs an activate, then the writes.

Each command goes out as a one-cycle strobe with a 2-bit code and its bank, row and column fields. Every spacing minimum is counted in controller clock cycles, and the block issues each command in the first cycle that all of its minimums allow. A separate data-enable output marks the cycles in which the write data for each column write must be driven. Requests enter through a valid/ready handshake. A new request is taken only once the current transaction has issued its last command.

Top module: `dram_wr_sequencer`

## Requirements
- R1: After reset, every bank is closed, `cmd_valid` and `wdata_en` are low, and `req_ready` is high. The first request to any bank after reset is therefore handled as page empty.
- R2: A request to an open bank whose open row equals the requested row (page hit) produces only column-write commands, with no precharge or activate.
- R3: A request to an open bank holding a different row (page miss) produces a precharge, then an activate to the new row at least T_RP cycles later, then the first column write at least T_RCDW cycles after the activate.
- R4: A request to a closed bank (page empty) produces an activate, then the first column write at least T_RCDW cycles after it.
- R5: A precharge marks its bank closed. An activate marks its bank open with the activated row, and that row is used to sort later requests.
- R6: A transaction issues `req_extra`+1 column writes spaced exactly T_CC cycles apart, at columns `req_col`, `req_col`+1, and so on, wrapping modulo 2^COL_W. Two column writes from different transactions are never closer than T_CC cycles.
- R7: For each column write issued in cycle t, `wdata_en` is high in cycles t+T_CWD through t+T_CWD+T_CC-1. It is low in every other cycle.
- R8: When `req_close` is set, a precharge to the bank follows the last column write. It comes no sooner than T_WRP cycles after that write and no sooner than T_RAS cycles after the bank's last activate, so the larger of the two limits governs. A miss precharge obeys the same two limits.
- R9: Each command is issued in the earliest cycle that satisfies all of its spacing minimums. That cycle is never before the cycle after acceptance, and never in the same cycle as the previous command of the transaction.
- R10: `req_ready` is high only while no transaction is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` falls in the cycle after acceptance.
- R11: Command codes on `cmd_code`: 1 = precharge, 2 = activate, 3 = column write. For an activate, `cmd_row` carries the requested row. For a column write, `cmd_bank`, `cmd_row` and `cmd_col` carry the target bank, row and column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | First column |
| req_extra | input | LEN_W | Column writes after the first |
| req_close | input | 1 | Precharge the bank after the last write |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 2 | 1 precharge, 2 activate, 3 column write |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_col | output | COL_W | Command column |
| wdata_en | output | 1 | Write data must be driven this cycle |

## Verification
The bench goes after the close-page precharge in two forms. In one, a single write leaves T_RAS as the governing limit. In the other, four writes push the precharge out to T_WRP after the last write. A design that honoured only one limit would issue the precharge early in one of the two. A miss that follows a hit on the same bank checks that the row compare uses the stored row; a design that compared only the open flag would skip the precharge and activate. A start column near the top of the column range checks the wrap. Two requests sent back to back on an open row check that the second is held off until the first finishes and that the cross-transaction write spacing holds. A reset while banks are open checks that every bank is left closed. The data-enable output is compared every cycle against packets the bench derives from the observed column writes, so a wrong delay or width shows as an early, late or stretched enable.

// File: rtl/dram_wr_pkg.sv
package dram_wr_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PRE  = 2'd1,
    CMD_ACT  = 2'd2,
    CMD_WR   = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_WR,
    ST_CLOSE
  } seq_st_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wr_bank_tracker.sv
// Per-bank open flag, open-row table and spacing countdowns.
// A countdown loaded with D-1 at the edge a command leaves reaches zero
// in time for a follower to appear exactly D cycles later.
module wr_bank_tracker
  import dram_wr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int T_RP      = 3,
  parameter int T_WRP     = 3,
  parameter int T_RAS     = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W    = $clog2(max_int(max_int(T_RP, T_WRP), T_RAS) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  cmd_e              upd_code,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  input  logic [BANK_W-1:0] q_bank,
  output logic              q_open,
  output logic [ROW_W-1:0]  q_row,
  output logic              q_pre_ok,
  output logic              q_act_ok
);

  logic [NUM_BANKS-1:0] open_q;
  logic [NUM_BANKS-1:0] pre_ok_v;
  logic [NUM_BANKS-1:0] act_ok_v;
  logic [ROW_W-1:0]     row_tab [NUM_BANKS];

  // Row table: written on activate only, no reset, so it can map to RAM.
  always_ff @(posedge clk) begin
    if (upd_valid && upd_code == CMD_ACT) row_tab[upd_bank] <= upd_row;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= '0;
    end else if (upd_valid) begin
      if (upd_code == CMD_ACT) open_q[upd_bank] <= 1'b1;
      else if (upd_code == CMD_PRE) open_q[upd_bank] <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [CNT_W-1:0] ras_c, rp_c, wrp_c;
    logic hit_me;
    assign hit_me = upd_valid && (upd_bank == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ras_c <= '0;
        rp_c  <= '0;
        wrp_c <= '0;
      end else begin
        if (hit_me && upd_code == CMD_ACT) ras_c <= CNT_W'(T_RAS - 1);
        else if (ras_c != '0)              ras_c <= ras_c - 1'b1;
        if (hit_me && upd_code == CMD_PRE) rp_c <= CNT_W'(T_RP - 1);
        else if (rp_c != '0)               rp_c <= rp_c - 1'b1;
        if (hit_me && upd_code == CMD_WR)  wrp_c <= CNT_W'(T_WRP - 1);
        else if (wrp_c != '0)              wrp_c <= wrp_c - 1'b1;
      end
    end

    assign pre_ok_v[g] = (ras_c == '0) && (wrp_c == '0);
    assign act_ok_v[g] = (rp_c == '0);
  end

  assign q_open   = open_q[q_bank];
  assign q_row    = row_tab[q_bank];
  assign q_pre_ok = pre_ok_v[q_bank];
  assign q_act_ok = act_ok_v[q_bank];

endmodule

// File: rtl/wr_data_strobe.sv
// Delays each column-write strobe by T_CWD cycles and stretches it to T_CC.
module wr_data_strobe #(
  parameter int T_CC  = 2,
  parameter int T_CWD = 3,   // at least 2
  localparam int SR_N = T_CWD - 1,
  localparam int DW   = $clog2(T_CC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_strobe,
  output logic wdata_en
);

  logic [SR_N-1:0] dly;
  logic [DW-1:0]   len_q, len_d;
  logic            trig;

  if (SR_N == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) dly <= '0;
      else     dly <= wr_strobe;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (rst) dly <= '0;
      else     dly <= {dly[SR_N-2:0], wr_strobe};
    end
  end

  assign trig = dly[SR_N-1];

  always_comb begin
    if (trig)              len_d = DW'(T_CC);
    else if (len_q != '0)  len_d = len_q - 1'b1;
    else                   len_d = len_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= '0;
      wdata_en <= 1'b0;
    end else begin
      len_q    <= len_d;
      wdata_en <= (len_d != '0);
    end
  end

endmodule

// File: rtl/dram_wr_sequencer.sv
module dram_wr_sequencer
  import dram_wr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int LEN_W     = 3,
  parameter int T_RP      = 3,
  parameter int T_RCDW    = 2,
  parameter int T_CC      = 2,
  parameter int T_CWD     = 3,
  parameter int T_WRP     = 3,
  parameter int T_RAS     = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_extra,
  input  logic              req_close,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              wdata_en
);

  localparam int GAP_W = $clog2(max_int(T_RCDW, T_CC) + 1);

  seq_st_e           st, st_nxt;
  cmd_e              code;
  logic              issue, accept;
  logic [BANK_W-1:0] t_bank, q_bank;
  logic [ROW_W-1:0]  t_row, q_row;
  logic [COL_W-1:0]  t_col;
  logic [LEN_W-1:0]  t_left;
  logic              t_close;
  logic              q_open, q_pre_ok, q_act_ok;
  logic [GAP_W-1:0]  rcd_cnt, cc_cnt;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign q_bank    = (st == ST_IDLE) ? req_bank : t_bank;

  wr_bank_tracker #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W),
    .T_RP(T_RP), .T_WRP(T_WRP), .T_RAS(T_RAS)
  ) u_banks (
    .clk(clk), .rst(rst),
    .upd_valid(issue), .upd_code(code), .upd_bank(t_bank), .upd_row(t_row),
    .q_bank(q_bank), .q_open(q_open), .q_row(q_row),
    .q_pre_ok(q_pre_ok), .q_act_ok(q_act_ok)
  );

  always_comb begin
    st_nxt = st;
    issue  = 1'b0;
    code   = CMD_NONE;
    unique case (st)
      ST_IDLE: if (req_valid) begin
        if (q_open && q_row == req_row) st_nxt = ST_WR;
        else if (q_open)                st_nxt = ST_PRE;
        else                            st_nxt = ST_ACT;
      end
      ST_PRE: if (q_pre_ok) begin
        issue = 1'b1; code = CMD_PRE; st_nxt = ST_ACT;
      end
      ST_ACT: if (q_act_ok) begin
        issue = 1'b1; code = CMD_ACT; st_nxt = ST_WR;
      end
      ST_WR: if (rcd_cnt == '0 && cc_cnt == '0) begin
        issue = 1'b1; code = CMD_WR;
        if (t_left == '0) st_nxt = t_close ? ST_CLOSE : ST_IDLE;
      end
      ST_CLOSE: if (q_pre_ok) begin
        issue = 1'b1; code = CMD_PRE; st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      t_bank    <= '0;
      t_row     <= '0;
      t_col     <= '0;
      t_left    <= '0;
      t_close   <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_code  <= CMD_NONE;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      rcd_cnt   <= '0;
      cc_cnt    <= '0;
    end else begin
      st        <= st_nxt;
      cmd_valid <= issue;
      cmd_code  <= code;
      cmd_bank  <= t_bank;
      cmd_row   <= t_row;
      cmd_col   <= t_col;
      if (accept) begin
        t_bank  <= req_bank;
        t_row   <= req_row;
        t_col   <= req_col;
        t_left  <= req_extra;
        t_close <= req_close;
      end else if (issue && code == CMD_WR) begin
        t_col  <= t_col + 1'b1;
        t_left <= t_left - 1'b1;
      end
      if (issue && code == CMD_ACT) rcd_cnt <= GAP_W'(T_RCDW - 1);
      else if (rcd_cnt != '0)       rcd_cnt <= rcd_cnt - 1'b1;
      if (issue && code == CMD_WR)  cc_cnt <= GAP_W'(T_CC - 1);
      else if (cc_cnt != '0)        cc_cnt <= cc_cnt - 1'b1;
    end
  end

  wr_data_strobe #(.T_CC(T_CC), .T_CWD(T_CWD)) u_strobe (
    .clk(clk), .rst(rst),
    .wr_strobe(cmd_valid && cmd_code == CMD_WR),
    .wdata_en(wdata_en)
  );

endmodule

// File: rtl/dram_wr_seq_chk.sv
module dram_wr_seq_chk
  import dram_wr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RP      = 3,
  parameter int T_RCDW    = 2,
  parameter int T_CC      = 2,
  parameter int T_CWD     = 3,
  parameter int T_WRP     = 3,
  parameter int T_RAS     = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic [1:0]        cmd_code,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              wdata_en
);

  localparam logic [7:0] SAT = 8'hFF;

  logic [7:0] since_act [NUM_BANKS];
  logic [7:0] since_pre [NUM_BANKS];
  logic [7:0] since_wrb [NUM_BANKS];
  logic [7:0] since_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_wr <= SAT;
      for (int b = 0; b < NUM_BANKS; b++) begin
        since_act[b] <= SAT;
        since_pre[b] <= SAT;
        since_wrb[b] <= SAT;
      end
    end else begin
      since_wr <= (cmd_valid && cmd_code == CMD_WR) ? 8'd1
                : (since_wr == SAT) ? SAT : since_wr + 8'd1;
      for (int b = 0; b < NUM_BANKS; b++) begin
        logic mine;
        mine = cmd_valid && (cmd_bank == BANK_W'(b));
        since_act[b] <= (mine && cmd_code == CMD_ACT) ? 8'd1
                      : (since_act[b] == SAT) ? SAT : since_act[b] + 8'd1;
        since_pre[b] <= (mine && cmd_code == CMD_PRE) ? 8'd1
                      : (since_pre[b] == SAT) ? SAT : since_pre[b] + 8'd1;
        since_wrb[b] <= (mine && cmd_code == CMD_WR) ? 8'd1
                      : (since_wrb[b] == SAT) ? SAT : since_wrb[b] + 8'd1;
      end
    end
  end

  AST_PRE_TO_ACT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == CMD_ACT) |-> since_pre[cmd_bank] >= 8'(T_RP)); // R3
  AST_ACT_TO_WR: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == CMD_WR) |-> since_act[cmd_bank] >= 8'(T_RCDW)); // R4
  AST_WR_SPACING: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == CMD_WR) |-> since_wr >= 8'(T_CC)); // R6
  AST_DATA_WINDOW: assert property (@(posedge clk) disable iff (rst)
    wdata_en |-> (since_wr <= 8'(T_CWD + T_CC - 1))); // R7
  AST_RAS_MIN: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == CMD_PRE) |-> since_act[cmd_bank] >= 8'(T_RAS)); // R8
  AST_WRP_MIN: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == CMD_PRE) |-> since_wrb[cmd_bank] >= 8'(T_WRP)); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_code != CMD_NONE); // R11

endmodule

bind dram_wr_sequencer dram_wr_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .T_RP(T_RP), .T_RCDW(T_RCDW), .T_CC(T_CC),
  .T_CWD(T_CWD), .T_WRP(T_WRP), .T_RAS(T_RAS)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
  .wdata_en(wdata_en)
);

// File: tb/tb_dram_wr_sequencer.sv
`timescale 1ns/1ps
module tb_dram_wr_sequencer;

  localparam int NB = 4, RW = 12, CW = 8, LW = 3;
  localparam int T_RP = 3, T_RCDW = 2, T_CC = 2, T_CWD = 3, T_WRP = 3, T_RAS = 8;
  localparam int C_PRE = 1, C_ACT = 2, C_WR = 3;
  localparam int K_EMPTY = 0, K_HIT = 1, K_MISS = 2;
  localparam int NV = 12;
  // {bank[27:26], row[25:14], col[13:6], extra[5:3], close[2], class[1:0]}
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 12'h011, 8'h10, 3'd1, 1'b0, 2'd0},
    {2'd0, 12'h011, 8'h20, 3'd0, 1'b0, 2'd1},
    {2'd0, 12'h022, 8'h30, 3'd2, 1'b0, 2'd2},
    {2'd1, 12'h005, 8'h00, 3'd0, 1'b1, 2'd0},
    {2'd1, 12'h005, 8'h40, 3'd1, 1'b0, 2'd0},
    {2'd1, 12'h005, 8'h50, 3'd0, 1'b1, 2'd1},
    {2'd0, 12'h022, 8'h60, 3'd3, 1'b1, 2'd1},
    {2'd0, 12'h022, 8'h70, 3'd0, 1'b0, 2'd0},
    {2'd2, 12'hABC, 8'hFE, 3'd2, 1'b0, 2'd0},
    {2'd2, 12'h123, 8'h08, 3'd0, 1'b0, 2'd2},
    {2'd3, 12'h3FF, 8'h00, 3'd3, 1'b1, 2'd0},
    {2'd0, 12'h7FF, 8'h80, 3'd0, 1'b1, 2'd2}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_close = 1'b0;
  logic [1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic [LW-1:0] req_extra = '0;
  logic req_ready, cmd_valid, wdata_en;
  logic [1:0] cmd_code, cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;

  dram_wr_sequencer dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_extra(req_extra), .req_close(req_close),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .wdata_en(wdata_en)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  int lg_t [256];
  int lg_code [256], lg_bank [256], lg_row [256], lg_col [256];
  int n_log = 0;
  bit exp_en [256];
  int h_act [NB], h_pre [NB], h_wr [NB];
  int h_wrany;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic clear_hist();
    for (int b = 0; b < NB; b++) begin
      h_act[b] = -1000; h_pre[b] = -1000; h_wr[b] = -1000;
    end
    h_wrany = -1000;
  endtask

  // Command log and data-enable model (R7), sampled at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (wdata_en || exp_en[cyc % 256]) begin
        n_cmp++;
        if (wdata_en != exp_en[cyc % 256]) begin
          n_bad++;
          $display("FAIL R7 wdata_en at cycle %0d: actual %0d expected %0d",
                   cyc, wdata_en, exp_en[cyc % 256]);
        end
      end
      exp_en[cyc % 256] = 1'b0;
      if (cmd_valid && n_log < 256) begin
        lg_t[n_log] = cyc; lg_code[n_log] = cmd_code; lg_bank[n_log] = cmd_bank;
        lg_row[n_log] = cmd_row; lg_col[n_log] = cmd_col;
        n_log++;
        if (cmd_code == 2'd3)
          for (int k = 0; k < T_CC; k++) exp_en[(cyc + T_CWD + k) % 256] = 1'b1;
      end
    end
  end

  // Called at a falling edge; returns at a falling edge.
  task automatic send(input logic [27:0] v, output int acc);
    req_bank = v[27:26]; req_row = v[25:14]; req_col = v[13:6];
    req_extra = v[5:3]; req_close = v[2]; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_txn(inout int idx, input int acc, input logic [27:0] v);
    int b, cls, nwr, nc, tprev, e, j, wi;
    int codes [12];
    string tag;
    b = v[27:26]; cls = v[1:0]; nwr = v[5:3] + 1;
    nc = 0;
    if (cls == K_MISS) codes[nc++] = C_PRE;
    if (cls != K_HIT)  codes[nc++] = C_ACT;
    for (int w = 0; w < nwr; w++) codes[nc++] = C_WR;
    if (v[2]) codes[nc++] = C_PRE;
    tprev = acc; wi = 0;
    for (int i = 0; i < nc; i++) begin
      j = idx + i;
      tag = (cls == K_HIT) ? "R2" : (cls == K_MISS) ? "R3" : "R4";
      if (j >= n_log) begin
        chk(1'b0, tag, "missing command", n_log - idx, i + 1);
        continue;
      end
      e = tprev + 1;
      if (codes[i] == C_PRE) begin
        e = imax(e, imax(h_act[b] + T_RAS, h_wr[b] + T_WRP));
        if (i == nc - 1 && v[2]) tag = "R8";
        h_pre[b] = e;
      end else if (codes[i] == C_ACT) begin
        e = imax(e, h_pre[b] + T_RP);
        h_act[b] = e;
      end else begin
        e = imax(e, imax(h_act[b] + T_RCDW, h_wrany + T_CC));
        if (wi > 0) tag = "R6";
        h_wr[b] = e; h_wrany = e;
      end
      chk(lg_code[j] == codes[i], "R11", "command code", lg_code[j], codes[i]);
      chk(lg_bank[j] == b, "R11", "command bank", lg_bank[j], b);
      chk(lg_t[j] == e, (wi == 0 && codes[i] == C_WR) ? "R9" : tag,
          "command cycle", lg_t[j], e);
      if (codes[i] != C_PRE)
        chk(lg_row[j] == int'(v[25:14]), "R5", "command row", lg_row[j], v[25:14]);
      if (codes[i] == C_WR) begin
        chk(lg_col[j] == int'(8'(v[13:6] + wi)), "R6", "column", lg_col[j],
            int'(8'(v[13:6] + wi)));
        wi++;
      end
      tprev = e;
    end
    idx += nc;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int idx, acc1, acc2;
    idx = 0;
    clear_hist();
    for (int i = 0; i < 256; i++) exp_en[i] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", cmd_valid, 0);
    chk(wdata_en == 1'b0, "R1", "wdata_en after reset", wdata_en, 0);

    // Vector table: classification, ordering and exact timing
    for (int i = 0; i < NV; i++) begin
      send(VEC[i], acc1);
      repeat (30) @(negedge clk);
      check_txn(idx, acc1, VEC[i]);
      chk(idx == n_log, "R10", "commands per transaction", n_log, idx);
    end

    // R10: back-to-back requests on an open row, second held off
    send({2'd2, 12'h123, 8'h10, 3'd1, 1'b0, 2'd1}, acc1);
    send({2'd2, 12'h123, 8'h20, 3'd0, 1'b0, 2'd1}, acc2);
    chk(acc2 == lg_t[n_log - 1] + 1, "R10", "second accept edge",
        acc2, lg_t[n_log - 1] + 1);
    repeat (30) @(negedge clk);
    check_txn(idx, acc1, {2'd2, 12'h123, 8'h10, 3'd1, 1'b0, 2'd1});
    check_txn(idx, acc2, {2'd2, 12'h123, 8'h20, 3'd0, 1'b0, 2'd1});
    chk(idx == n_log, "R10", "commands back to back", n_log, idx);

    // R1: reset with banks open closes every bank
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_hist();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after second reset", req_ready, 1);
    send({2'd2, 12'h123, 8'h00, 3'd0, 1'b0, 2'd0}, acc1);
    repeat (30) @(negedge clk);
    check_txn(idx, acc1, {2'd2, 12'h123, 8'h00, 3'd0, 1'b0, 2'd0});
    chk(idx == n_log, "R1", "commands after reset", n_log, idx);

    report();
  end

endmodule